// File: doc/BRIEF.md
# Thread Wait-Mask Controller

This block keeps the stall bookkeeping for a small set of hardware threads in a fine-grained multithreaded core. There are four independent stall causes: an instruction-fetch miss, a store-buffer wait, a general "other" cause, and an added resource stall. Each cause holds its own wait-mask bit for every thread. A one-cycle stall pulse from a cause sets that cause's bit for the thread. A one-cycle ready pulse from the same cause clears it. Because the bits are kept apart, causes can finish in any order, and a thread only becomes eligible again once every cause that blocked it has reported ready.

From the masks and the ready pulses of the current cycle, the block forms a per-thread completion flag. When the scheduler raises its resume request for a thread, the block also produces a start control or a thaw control for that thread. Start means nothing blocks the thread any more. Thaw means at least one masked cause has not yet reported ready. A small per-thread tracker with three states (Ready, Run, Wait) follows these events so that the scheduler can see where each thread stands.

Top module: `thread_wait_ctrl`

## Requirements
- R1: Bit `c*T+t` of the flat stall, ready and mask vectors belongs to cause `c` and thread `t`, where T is the thread count. The cause numbers are fetch miss = 0, store wait = 1, other = 2 and resource = 3. A stall pulse on a bit sets that mask bit on the next clock edge.
- R2: A ready pulse clears the matching mask bit on the next clock edge. A ready pulse on a bit that is already clear changes nothing. Pulses for one cause or thread never change the bits of another.
- R3: A synchronous active-high reset clears every mask bit and puts every thread in Ready (state code 00).
- R4: `complete_o[t]` is high in the same cycle exactly when, for every cause, the thread's mask bit is clear or that cause's ready bit is high, and at least one of the thread's mask bits is set.
- R5: `start_o[t]` is high in the same cycle exactly when `resume_req_i[t]` is high and, for every cause, the mask bit is clear or the matching ready bit is high.
- R6: `thaw_o[t]` is high in the same cycle exactly when `resume_req_i[t]` is high and some cause has its mask bit set while its ready bit is low. Start and thaw are never high together.
- R7: Each thread's state appears on `state_o[2t+1:2t]` with the codes Ready = 00, Run = 01 and Wait = 10. A stall pulse of any cause for a thread in Ready or Run puts it in Wait on the next edge.
- R8: A thread in Wait moves to Ready on the next edge when its completion or start condition holds, unless a new stall pulse for it arrives in the same cycle. In that case it stays in Wait.
- R9: A thread in Ready moves to Run on the next edge when its start condition holds and no stall arrives. A thread in Run stays in Run until a stall arrives.
- R10: A thread stalled by two causes stays in Wait, and keeps the other bit set, while only one of the causes has reported ready. It leaves Wait only once both have reported ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | CAUSES*THREADS | One-cycle stall pulses, bit c*T+t |
| ready_i | input | CAUSES*THREADS | One-cycle ready pulses, bit c*T+t |
| resume_req_i | input | THREADS | Scheduler resume request per thread |
| wait_mask_o | output | CAUSES*THREADS | Registered wait-mask bits, bit c*T+t |
| complete_o | output | THREADS | Per-thread completion flag |
| start_o | output | THREADS | Start control to the scheduler |
| thaw_o | output | THREADS | Thaw control to the scheduler |
| state_o | output | 2*THREADS | Per-thread state code |

## Verification
Completion, start and thaw depend only on the registered masks and the inputs of the current cycle, so they are due in the same cycle as the stimulus. The bench drives inputs just after the falling edge and samples these three outputs 2 ns later, before the next rising edge. The mask bits and the thread states change one rising edge after the stimulus. The bench samples them at the following falling edge, before it drives anything new, and compares them with its own model, which it advances at that same point.

// File: rtl/thread_wait_pkg.sv
package thread_wait_pkg;

    // Stall cause numbering; the flat vectors place cause c at bits [c*T +: T]
    localparam int unsigned CAUSE_COUNT  = 4;
    localparam int unsigned CAUSE_FETCH  = 0;
    localparam int unsigned CAUSE_STORE  = 1;
    localparam int unsigned CAUSE_OTHER  = 2;
    localparam int unsigned CAUSE_RSRC   = 3;

    localparam int unsigned THREAD_COUNT = 4;

    typedef enum logic [1:0] {
        TS_READY = 2'b00,
        TS_RUN   = 2'b01,
        TS_WAIT  = 2'b10
    } thr_state_e;

    // A cause lets a thread go when it is not masked or has just reported ready
    function automatic logic cause_released(input logic masked, input logic rdy);
        return (~masked) | rdy;
    endfunction

    // A cause still holds a thread when masked and not yet ready
    function automatic logic cause_holding(input logic masked, input logic rdy);
        return masked & ~rdy;
    endfunction

endpackage

// File: rtl/wait_mask_bank.sv
module wait_mask_bank #(
    parameter int unsigned THREADS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] stall_i,
    input  logic [THREADS-1:0] ready_i,
    output logic [THREADS-1:0] mask_o
);

    logic [THREADS-1:0] mask_q;

    // Stall sets the bit; ready clears it; otherwise the bit holds
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= stall_i | (mask_q & ~ready_i);
        end
    end

    assign mask_o = mask_q;

    a_r3_reset_clears : assert property (@(posedge clk) rst |=> (mask_o == '0));

    for (genvar t = 0; t < THREADS; t++) begin : g_chk
        a_r1_stall_sets : assert property (@(posedge clk) disable iff (rst)
            stall_i[t] |=> mask_o[t]);
        a_r2_ready_clears : assert property (@(posedge clk) disable iff (rst)
            (ready_i[t] && !stall_i[t]) |=> !mask_o[t]);
        a_r2_idle_stays_clear : assert property (@(posedge clk) disable iff (rst)
            (!mask_o[t] && !stall_i[t]) |=> !mask_o[t]);
        a_r1_legal_pulses : assert property (@(posedge clk) disable iff (rst)
            !(stall_i[t] && ready_i[t]));
    end

endmodule

// File: rtl/thread_release_logic.sv
module thread_release_logic
    import thread_wait_pkg::*;
#(
    parameter int unsigned THREADS = 4,
    parameter int unsigned CAUSES  = 4,
    localparam int unsigned MW     = THREADS * CAUSES
) (
    input  logic [MW-1:0]      mask_i,
    input  logic [MW-1:0]      ready_i,
    input  logic [THREADS-1:0] resume_req_i,
    output logic [THREADS-1:0] complete_o,
    output logic [THREADS-1:0] start_o,
    output logic [THREADS-1:0] thaw_o
);

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic all_released;
        logic any_holding;
        logic any_masked;

        always_comb begin
            all_released = 1'b1;
            any_holding  = 1'b0;
            any_masked   = 1'b0;
            for (int c = 0; c < CAUSES; c++) begin
                all_released = all_released & cause_released(mask_i[c*THREADS+t], ready_i[c*THREADS+t]);
                any_holding  = any_holding  | cause_holding(mask_i[c*THREADS+t], ready_i[c*THREADS+t]);
                any_masked   = any_masked   | mask_i[c*THREADS+t];
            end
        end

        assign complete_o[t] = all_released & any_masked;
        assign start_o[t]    = resume_req_i[t] & all_released;
        assign thaw_o[t]     = resume_req_i[t] & any_holding;
    end

endmodule

// File: rtl/thread_state_tracker.sv
module thread_state_tracker
    import thread_wait_pkg::*;
#(
    parameter int unsigned THREADS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [THREADS-1:0]   stall_any_i,
    input  logic [THREADS-1:0]   complete_i,
    input  logic [THREADS-1:0]   start_i,
    output logic [2*THREADS-1:0] state_o
);

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        thr_state_e st_q, st_d;

        always_comb begin
            st_d = st_q;
            if (stall_any_i[t]) begin
                st_d = TS_WAIT;
            end else begin
                unique case (st_q)
                    TS_READY: if (start_i[t]) st_d = TS_RUN;
                    TS_RUN:   st_d = TS_RUN;
                    TS_WAIT:  if (complete_i[t] || start_i[t]) st_d = TS_READY;
                    default:  st_d = TS_READY;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q <= TS_READY;
            end else begin
                st_q <= st_d;
            end
        end

        assign state_o[2*t +: 2] = st_q;

        a_r7_stall_enters_wait : assert property (@(posedge clk) disable iff (rst)
            stall_any_i[t] |=> (state_o[2*t +: 2] == TS_WAIT));
        a_r8_wait_released : assert property (@(posedge clk) disable iff (rst)
            ((state_o[2*t +: 2] == TS_WAIT) && (complete_i[t] || start_i[t]) && !stall_any_i[t])
            |=> (state_o[2*t +: 2] == TS_READY));
        a_r9_run_holds : assert property (@(posedge clk) disable iff (rst)
            ((state_o[2*t +: 2] == TS_RUN) && !stall_any_i[t]) |=> (state_o[2*t +: 2] == TS_RUN));
        a_r3_reset_ready : assert property (@(posedge clk)
            rst |=> (state_o[2*t +: 2] == TS_READY));
    end

endmodule

// File: rtl/thread_wait_ctrl.sv
module thread_wait_ctrl
    import thread_wait_pkg::*;
#(
    parameter int unsigned THREADS = THREAD_COUNT,
    parameter int unsigned CAUSES  = CAUSE_COUNT,
    localparam int unsigned MW     = THREADS * CAUSES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MW-1:0]        stall_i,
    input  logic [MW-1:0]        ready_i,
    input  logic [THREADS-1:0]   resume_req_i,
    output logic [MW-1:0]        wait_mask_o,
    output logic [THREADS-1:0]   complete_o,
    output logic [THREADS-1:0]   start_o,
    output logic [THREADS-1:0]   thaw_o,
    output logic [2*THREADS-1:0] state_o
);

    logic [MW-1:0]      mask;
    logic [THREADS-1:0] stall_any;

    // One mask bank per stall cause
    for (genvar c = 0; c < CAUSES; c++) begin : g_cause
        wait_mask_bank #(.THREADS(THREADS)) bank_i (
            .clk     (clk),
            .rst     (rst),
            .stall_i (stall_i[c*THREADS +: THREADS]),
            .ready_i (ready_i[c*THREADS +: THREADS]),
            .mask_o  (mask[c*THREADS +: THREADS])
        );
    end

    // Any cause stalling a thread this cycle
    for (genvar t = 0; t < THREADS; t++) begin : g_stall_or
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int c = 0; c < CAUSES; c++) begin
                hit = hit | stall_i[c*THREADS+t];
            end
        end
        assign stall_any[t] = hit;
    end

    thread_release_logic #(.THREADS(THREADS), .CAUSES(CAUSES)) release_i (
        .mask_i       (mask),
        .ready_i      (ready_i),
        .resume_req_i (resume_req_i),
        .complete_o   (complete_o),
        .start_o      (start_o),
        .thaw_o       (thaw_o)
    );

    thread_state_tracker #(.THREADS(THREADS)) tracker_i (
        .clk         (clk),
        .rst         (rst),
        .stall_any_i (stall_any),
        .complete_i  (complete_o),
        .start_i     (start_o),
        .state_o     (state_o)
    );

    assign wait_mask_o = mask;

    for (genvar t = 0; t < THREADS; t++) begin : g_chk
        logic thr_masked;
        always_comb begin
            thr_masked = 1'b0;
            for (int c = 0; c < CAUSES; c++) begin
                thr_masked = thr_masked | mask[c*THREADS+t];
            end
        end
        a_r6_start_thaw_excl : assert property (@(posedge clk) disable iff (rst)
            !(start_o[t] && thaw_o[t]));
        a_r4_complete_needs_mask : assert property (@(posedge clk) disable iff (rst)
            complete_o[t] |-> thr_masked);
        a_r10_wait_iff_masked : assert property (@(posedge clk) disable iff (rst)
            (state_o[2*t +: 2] == TS_WAIT) == thr_masked);
    end

endmodule

// File: tb/thread_wait_ctrl_tb_top.sv
module thread_wait_ctrl_tb_top;

    localparam int NT = 4;
    localparam int NC = 4;
    localparam int MW = NT * NC;
    localparam int NV = 8;

    // Table: stall, ready, resume request, expected mask after the edge
    localparam logic [MW-1:0] V_STALL [NV] = '{16'h0001, 16'h0010, 16'h0000, 16'h0000,
                                              16'h8000, 16'h0200, 16'h0000, 16'h0000};
    localparam logic [MW-1:0] V_READY [NV] = '{16'h0000, 16'h0000, 16'h0001, 16'h0001,
                                              16'h0010, 16'h0000, 16'h0400, 16'h8200};
    localparam logic [NT-1:0] V_REQ   [NV] = '{4'h0, 4'h0, 4'h1, 4'h0,
                                              4'h1, 4'h0, 4'h2, 4'h8};
    localparam logic [MW-1:0] V_MASK  [NV] = '{16'h0001, 16'h0011, 16'h0010, 16'h0010,
                                              16'h8000, 16'h8200, 16'h8200, 16'h0000};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [MW-1:0]   stall_i = '0;
    logic [MW-1:0]   ready_i = '0;
    logic [NT-1:0]   resume_req_i = '0;
    logic [MW-1:0]   wait_mask_o;
    logic [NT-1:0]   complete_o, start_o, thaw_o;
    logic [2*NT-1:0] state_o;

    int n_chk = 0;
    int n_err = 0;

    logic [MW-1:0] m_mask = '0;
    logic [1:0]    m_st [NT] = '{default: 2'b00};

    always #10 clk = ~clk;

    thread_wait_ctrl dut_i (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .ready_i      (ready_i),
        .resume_req_i (resume_req_i),
        .wait_mask_o  (wait_mask_o),
        .complete_o   (complete_o),
        .start_o      (start_o),
        .thaw_o       (thaw_o),
        .state_o      (state_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({tag, " R1/R2 mask"}, 32'(wait_mask_o), 32'(m_mask));
        for (int t = 0; t < NT; t++) begin
            chk({tag, " R7/R8/R9 state"}, 32'(state_o[2*t +: 2]), 32'(m_st[t]));
        end
    endtask

    // Drive one cycle from a falling edge; returns at the next falling edge
    task automatic run_cycle(input logic [MW-1:0] s, input logic [MW-1:0] r, input logic [NT-1:0] q);
        logic [NT-1:0] e_comp, e_start, e_thaw, any_stall;
        logic [1:0]    n_st [NT];
        stall_i = s;
        ready_i = r;
        resume_req_i = q;
        for (int t = 0; t < NT; t++) begin
            logic rel, hold, msk;
            rel = 1'b1; hold = 1'b0; msk = 1'b0; any_stall[t] = 1'b0;
            for (int c = 0; c < NC; c++) begin
                if (m_mask[c*NT+t] && !r[c*NT+t]) begin rel = 1'b0; hold = 1'b1; end
                if (m_mask[c*NT+t]) msk = 1'b1;
                if (s[c*NT+t]) any_stall[t] = 1'b1;
            end
            e_comp[t]  = rel && msk;
            e_start[t] = q[t] && rel;
            e_thaw[t]  = q[t] && hold;
            if (any_stall[t]) n_st[t] = 2'b10;
            else if (m_st[t] == 2'b00 && e_start[t]) n_st[t] = 2'b01;
            else if (m_st[t] == 2'b10 && (e_comp[t] || e_start[t])) n_st[t] = 2'b00;
            else n_st[t] = m_st[t];
        end
        #2;
        chk("R4 complete", 32'(complete_o), 32'(e_comp));
        chk("R5 start", 32'(start_o), 32'(e_start));
        chk("R6 thaw", 32'(thaw_o), 32'(e_thaw));
        @(posedge clk);
        @(negedge clk);
        m_mask = s | (m_mask & ~r);
        for (int t = 0; t < NT; t++) m_st[t] = n_st[t];
        check_regs("cycle");
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog R1: actual timeout expected run completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_regs("R3 reset");
        chk("R3 reset complete", 32'(complete_o), 32'h0);
        rst = 1'b0;

        // Table walk: R10 two causes on thread 0, R2 ready on clear bits
        for (int v = 0; v < NV; v++) begin
            run_cycle(V_STALL[v], V_READY[v], V_REQ[v]);
            chk("R1/R2/R10 table mask", 32'(wait_mask_o), 32'(V_MASK[v]));
        end
        chk("R10 thread 0 back to Ready", 32'(state_o[1:0]), 32'h0);

        // R9: start from Ready goes to Run, Run holds without stalls
        run_cycle('0, '0, 4'h1);
        chk("R9 thread 0 in Run", 32'(state_o[1:0]), 32'h1);
        run_cycle('0, '0, 4'h0);
        chk("R9 Run holds", 32'(state_o[1:0]), 32'h1);

        // R7: stall from Run by the resource cause (bit 12)
        run_cycle(16'h1000, '0, 4'h0);
        chk("R7 Run to Wait", 32'(state_o[1:0]), 32'h2);

        // R8: release together with a new stall from another cause keeps Wait
        run_cycle(16'h0001, 16'h1000, 4'h1);
        chk("R8 stall wins over release", 32'(state_o[1:0]), 32'h2);
        chk("R8 mask moved to fetch cause", 32'(wait_mask_o), 32'h0001);
        run_cycle('0, 16'h0001, 4'h0);
        chk("R8 Wait to Ready", 32'(state_o[1:0]), 32'h0);

        // Random single-cycle pulses against the model
        for (int i = 0; i < 600; i++) begin
            logic [MW-1:0] s, r;
            for (int b = 0; b < MW; b++) begin
                s[b] = ($urandom % 10) == 0;
                r[b] = !s[b] && (($urandom % 3) == 0);
            end
            run_cycle(s, r, 4'($urandom));
        end

        // R3: reset in the middle of activity, with a stall present
        run_cycle(16'hffff, '0, 4'h0);
        stall_i = 16'h0f0f;
        rst = 1'b1;
        @(negedge clk);
        m_mask = '0;
        for (int t = 0; t < NT; t++) m_st[t] = 2'b00;
        check_regs("R3 mid-run reset");
        stall_i = '0;
        rst = 1'b0;
        run_cycle('0, '0, 4'hf);
        chk("R3 R9 all threads Run after reset", 32'(state_o), 32'h55);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule